// File: doc/BRIEF.md
# SAR ADC Conversion Timing Sequencer

This block produces the timing for a successive-approximation analog-to-digital converter. It divides the system clock down to a conversion clock and then steps through up to three phases. The first is an optional settling wait. The second is input sampling. The third is bit-by-bit conversion. A single-cycle completion strobe follows the last phase. The analog comparator and the result register are not part of this block. They follow the phase outputs and the conversion-clock enable.

Software writes two register ports. The mode port selects the clock divisor and the conversion-length variant. The control port holds an enable bit and a start bit. A trigger-mode input selects how a conversion begins:
- **Software mode:** the start bit alone begins a conversion, and conversions repeat back to back while start stays set.
- **Hardware no-wait mode:** an external trigger pulse begins a conversion.
- **Hardware wait mode:** an external trigger pulse begins a conversion that is preceded by a settling phase.

Unsafe writes are refused, and each refused write raises an error flag.

Top module: `adc_seq_top`

## Requirements
- R1: After a synchronous reset, busy, done, cfg_err, conv_clk_en and all three phase outputs are 0.
- R2: mode_div picks the conversion-clock divisor of fCLK: 0 gives /32, 1 gives /16, 2 gives /8, 3 gives /6, 4 gives /5, 5 gives /4 and 6 gives /2. A conversion without a wait phase keeps busy high for exactly 19 × divisor system-clock cycles under variant 0.
- R3: While busy, exactly one phase output is high, and none is high while idle. Under variant 0 (mode_var = 0), sampling lasts 7 conversion clocks and bit conversion lasts 12 conversion clocks.
- R4: Under variant 1 (mode_var = 1), a conversion lasts 17 conversion clocks, of which 5 are sampling.
- R5: With trig_mode[1] = 1 (hardware wait), a trigger starts a 2-conversion-clock wait phase before sampling. A variant-0 conversion then totals 21 conversion clocks (672 fCLK at /32, 126 fCLK at /6).
- R6: With trig_mode = 01 (hardware no-wait), no conversion starts until hw_trig is seen while enable and start are set. The conversion then has no wait phase.
- R7: A mode write while enable or start is 1 leaves the divisor and variant unchanged and sets cfg_err.
- R8: A control write with start = 1 and enable = 0 is ignored entirely and sets cfg_err. Any accepted write clears cfg_err.
- R9: A mode write with mode_div = 7 or mode_var of 2 or 3 is ignored and sets cfg_err.
- R10: done is a one-cycle pulse in the cycle right after the last busy cycle of a conversion. In the non-repeating case, busy is low in that cycle.
- R11: With trig_mode = 00, while start stays 1, a new conversion begins with no idle cycle: busy stays high through done, and successive done pulses are exactly one conversion length apart.
- R12: hw_trig while busy has no effect on the running conversion's length.
- R13: A control write that clears enable aborts the conversion: busy is low two cycles after the write is presented, and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock fCLK |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the mode fields |
| mode_div | input | 3 | Divisor code to write |
| mode_var | input | 2 | Conversion-length variant to write |
| ctl_wr | input | 1 | Write strobe for the control fields |
| ctl_en | input | 1 | Comparator enable bit to write |
| ctl_start | input | 1 | Start bit to write |
| trig_mode | input | 2 | 00 software, 01 hardware no-wait, 1x hardware wait |
| hw_trig | input | 1 | Hardware trigger pulse |
| conv_clk_en | output | 1 | One fCLK cycle enable per conversion clock while busy |
| ph_wait | output | 1 | Settling wait phase active |
| ph_sample | output | 1 | Sampling phase active |
| ph_convert | output | 1 | Bit-conversion phase active |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Single-cycle completion strobe |
| cfg_err | output | 1 | Last register write was refused |

## Verification
The bench goes after the odd divisors (/5 and /6). A reload counter that is off by one there would stretch or shorten every conversion by 19 fCLK cycles. It also checks the split between the sampling, wait and bit phases. A phase decoder with a wrong boundary would still give the right total but the wrong sample count. Refused writes (mode while enabled, start without enable, illegal codes) are followed by a real conversion, so a design that let them through would show up as a changed conversion length or a conversion that starts on its own. Back-to-back software conversions, retriggers during a conversion and an enable-clear abort are also driven. These expose designs that insert an idle cycle, restart on a second trigger, or emit a stray done.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  localparam int DIV_SEL_W = 3;
  localparam int VAR_W     = 2;
  localparam int DIV_W     = 6;

  typedef enum logic [1:0] {
    TRG_SW      = 2'b00,
    TRG_HW_FAST = 2'b01,
    TRG_HW_SLOW = 2'b10,
    TRG_HW_ALT  = 2'b11
  } trig_mode_e;

  function automatic logic [DIV_W-1:0] div_value(input logic [DIV_SEL_W-1:0] sel);
    case (sel)
      3'd0:    div_value = 6'd32;
      3'd1:    div_value = 6'd16;
      3'd2:    div_value = 6'd8;
      3'd3:    div_value = 6'd6;
      3'd4:    div_value = 6'd5;
      3'd5:    div_value = 6'd4;
      3'd6:    div_value = 6'd2;
      default: div_value = 6'd0;
    endcase
  endfunction

  function automatic logic div_legal(input logic [DIV_SEL_W-1:0] sel);
    div_legal = (sel != 3'd7);
  endfunction
endpackage

// File: rtl/adc_cfg_regs.sv
`timescale 1ns/1ps
module adc_cfg_regs
  import adc_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_wr,
  input  logic [DIV_SEL_W-1:0] mode_div,
  input  logic [VAR_W-1:0]     mode_var,
  input  logic                 ctl_wr,
  input  logic                 ctl_en,
  input  logic                 ctl_start,
  output logic [DIV_SEL_W-1:0] div_q,
  output logic [VAR_W-1:0]     var_q,
  output logic                 en_q,
  output logic                 start_q,
  output logic                 cfg_err
);
  localparam logic [VAR_W-1:0] VAR_LIMIT = VAR_W'(2);

  logic mode_ok;
  logic ctl_ok;

  always_comb begin
    mode_ok = !en_q && !start_q && div_legal(mode_div) && (mode_var < VAR_LIMIT);
    ctl_ok  = !(ctl_start && !ctl_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      var_q   <= '0;
      en_q    <= 1'b0;
      start_q <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      if (mode_wr && mode_ok) begin
        div_q <= mode_div;
        var_q <= mode_var;
      end
      if (ctl_wr && ctl_ok) begin
        en_q    <= ctl_en;
        start_q <= ctl_start;
      end
      if (mode_wr || ctl_wr)
        cfg_err <= (mode_wr && !mode_ok) || (ctl_wr && !ctl_ok);
    end
  end
endmodule

// File: rtl/adc_clk_div.sv
`timescale 1ns/1ps
module adc_clk_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (!run || cnt == '0)
      cnt <= div_val - ONE;
    else
      cnt <= cnt - ONE;
  end
endmodule

// File: rtl/adc_phase_seq.sv
`timescale 1ns/1ps
module adc_phase_seq #(
  parameter int PH_W     = 5,
  parameter int WAIT_LEN = 2,
  parameter int SAMP_A   = 7,
  parameter int CONV_A   = 19,
  parameter int SAMP_B   = 5,
  parameter int CONV_B   = 17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       en_q,
  input  logic       start_q,
  input  logic [1:0] trig_mode,
  input  logic       hw_trig,
  input  logic       var_b,
  output logic       busy,
  output logic       done,
  output logic       ph_wait,
  output logic       ph_sample,
  output logic       ph_convert
);
  localparam logic [PH_W-1:0] WL  = PH_W'(WAIT_LEN);
  localparam logic [PH_W-1:0] SA  = PH_W'(SAMP_A);
  localparam logic [PH_W-1:0] CA  = PH_W'(CONV_A);
  localparam logic [PH_W-1:0] SB  = PH_W'(SAMP_B);
  localparam logic [PH_W-1:0] CB  = PH_W'(CONV_B);
  localparam logic [PH_W-1:0] ONE = PH_W'(1);

  logic            busy_q, done_q, wait_q;
  logic [PH_W-1:0] ph_cnt;
  logic [PH_W-1:0] pre_len, samp_len, conv_len, total, samp_end;
  logic            sw_mode, accept, last;

  always_comb begin
    sw_mode  = (trig_mode == 2'b00);
    samp_len = var_b ? SB : SA;
    conv_len = var_b ? CB : CA;
    pre_len  = wait_q ? WL : '0;
    total    = pre_len + conv_len;
    samp_end = pre_len + samp_len;
    accept   = !busy_q && en_q && start_q && (sw_mode || hw_trig);
    last     = busy_q && tick && (ph_cnt == total - ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wait_q <= 1'b0;
      ph_cnt <= '0;
    end else begin
      done_q <= 1'b0;
      if (!en_q) begin
        busy_q <= 1'b0;
        wait_q <= 1'b0;
        ph_cnt <= '0;
      end else if (accept) begin
        busy_q <= 1'b1;
        wait_q <= !sw_mode && trig_mode[1];
        ph_cnt <= '0;
      end else if (last) begin
        done_q <= 1'b1;
        ph_cnt <= '0;
        wait_q <= 1'b0;
        busy_q <= sw_mode && start_q;
      end else if (busy_q && tick) begin
        ph_cnt <= ph_cnt + ONE;
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign ph_wait    = busy_q && (ph_cnt < pre_len);
  assign ph_sample  = busy_q && (ph_cnt >= pre_len) && (ph_cnt < samp_end);
  assign ph_convert = busy_q && (ph_cnt >= samp_end);
endmodule

// File: rtl/adc_seq_top.sv
`timescale 1ns/1ps
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int PH_W     = 5,
  parameter int WAIT_LEN = 2,
  parameter int SAMP_A   = 7,
  parameter int CONV_A   = 19,
  parameter int SAMP_B   = 5,
  parameter int CONV_B   = 17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_wr,
  input  logic [2:0] mode_div,
  input  logic [1:0] mode_var,
  input  logic       ctl_wr,
  input  logic       ctl_en,
  input  logic       ctl_start,
  input  logic [1:0] trig_mode,
  input  logic       hw_trig,
  output logic       conv_clk_en,
  output logic       ph_wait,
  output logic       ph_sample,
  output logic       ph_convert,
  output logic       busy,
  output logic       done,
  output logic       cfg_err
);
  logic [DIV_SEL_W-1:0] div_q;
  logic [VAR_W-1:0]     var_q;
  logic                 en_q, start_q;
  logic [DIV_W-1:0]     div_val;

  adc_cfg_regs u_cfg (
    .clk(clk), .rst(rst),
    .mode_wr(mode_wr), .mode_div(mode_div), .mode_var(mode_var),
    .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_start(ctl_start),
    .div_q(div_q), .var_q(var_q), .en_q(en_q), .start_q(start_q),
    .cfg_err(cfg_err)
  );

  assign div_val = div_value(div_q);

  adc_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(busy), .div_val(div_val), .tick(conv_clk_en)
  );

  adc_phase_seq #(
    .PH_W(PH_W), .WAIT_LEN(WAIT_LEN),
    .SAMP_A(SAMP_A), .CONV_A(CONV_A), .SAMP_B(SAMP_B), .CONV_B(CONV_B)
  ) u_seq (
    .clk(clk), .rst(rst), .tick(conv_clk_en),
    .en_q(en_q), .start_q(start_q), .trig_mode(trig_mode), .hw_trig(hw_trig),
    .var_b(var_q[0]),
    .busy(busy), .done(done),
    .ph_wait(ph_wait), .ph_sample(ph_sample), .ph_convert(ph_convert)
  );
endmodule

// File: rtl/adc_seq_chk.sv
`timescale 1ns/1ps
module adc_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       mode_wr,
  input logic       ctl_wr,
  input logic       ctl_en,
  input logic       ctl_start,
  input logic       busy,
  input logic       done,
  input logic       ph_wait,
  input logic       ph_sample,
  input logic       ph_convert,
  input logic       cfg_err,
  input logic [2:0] div_q,
  input logic       en_q,
  input logic       start_q
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> $past(busy));
  // R3
  phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> $onehot({ph_wait, ph_sample, ph_convert}));
  // R3
  phase_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(ph_wait || ph_sample || ph_convert));
  // R7
  mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && (en_q || start_q)) |=> ($stable(div_q) && cfg_err));
  // R8
  start_no_en_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_start && !ctl_en) |=> (cfg_err && $stable(en_q) && $stable(start_q)));
  // R13
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !ctl_en && !ctl_start) |-> ##2 (!busy && !done));
endmodule

bind adc_seq_top adc_seq_chk chk_i (
  .clk(clk), .rst(rst), .mode_wr(mode_wr), .ctl_wr(ctl_wr),
  .ctl_en(ctl_en), .ctl_start(ctl_start), .busy(busy), .done(done),
  .ph_wait(ph_wait), .ph_sample(ph_sample), .ph_convert(ph_convert),
  .cfg_err(cfg_err), .div_q(div_q), .en_q(en_q), .start_q(start_q)
);

// File: tb/adc_seq_top_tb_top.sv
`timescale 1ns/1ps
module adc_seq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_wr = 1'b0;
  logic [2:0] mode_div = '0;
  logic [1:0] mode_var = '0;
  logic       ctl_wr = 1'b0, ctl_en = 1'b0, ctl_start = 1'b0;
  logic [1:0] trig_mode = 2'b00;
  logic       hw_trig = 1'b0;
  logic       conv_clk_en, ph_wait, ph_sample, ph_convert, busy, done, cfg_err;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  adc_seq_top dut_i (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_div(mode_div), .mode_var(mode_var),
    .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_start(ctl_start), .trig_mode(trig_mode),
    .hw_trig(hw_trig), .conv_clk_en(conv_clk_en), .ph_wait(ph_wait),
    .ph_sample(ph_sample), .ph_convert(ph_convert), .busy(busy), .done(done),
    .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [2:0] d, input logic [1:0] v);
    mode_div = d; mode_var = v; mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic wr_ctl(input logic en, input logic st);
    ctl_en = en; ctl_start = st; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic measure(input int retrig_at, output int nb, output int nw,
                         output int ns, output int nc, output int nd);
    nb = 0; nw = 0; ns = 0; nc = 0; nd = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin nd = 1; break; end
      if (busy) nb++;
      if (ph_wait) nw++;
      if (ph_sample) ns++;
      if (ph_convert) nc++;
      hw_trig = (i == retrig_at);
      @(negedge clk);
    end
    hw_trig = 1'b0;
  endtask

  task automatic run_sw(input logic [2:0] d, input logic [1:0] v, input int dv,
                        input int len, input int samp, input string req);
    int nb, nw, ns, nc, nd;
    wr_ctl(1'b0, 1'b0);
    trig_mode = 2'b00;
    wr_mode(d, v);
    wr_ctl(1'b1, 1'b1);
    wr_ctl(1'b1, 1'b0);
    measure(-1, nb, nw, ns, nc, nd);
    chk({req, " busy length"}, nb, len * dv);
    chk({req, " R3 sample length"}, ns, samp * dv);
    chk({req, " R3 convert length"}, nc, (len - samp) * dv);
    chk({req, " wait length"}, nw, 0);
    chk("R10 one done", nd, 1);
    chk("R10 busy low at done", int'(busy), 0);
    @(negedge clk);
    chk("R10 done one cycle", int'(done), 0);
  endtask

  task automatic run_hw(input logic [2:0] d, input logic [1:0] tm, input int dv,
                        input int len, input int wt, input string req);
    int nb, nw, ns, nc, nd;
    wr_ctl(1'b0, 1'b0);
    trig_mode = tm;
    wr_mode(d, 2'b00);
    wr_ctl(1'b1, 1'b1);
    repeat (20) begin
      @(negedge clk);
      if (busy) chk({req, " no start without trigger"}, 1, 0);
    end
    hw_trig = 1'b1;
    @(negedge clk);
    hw_trig = 1'b0;
    measure(-1, nb, nw, ns, nc, nd);
    chk({req, " busy length"}, nb, len * dv);
    chk({req, " wait length"}, nw, wt * dv);
    chk({req, " sample length"}, ns, 7 * dv);
    chk({req, " done seen"}, nd, 1);
  endtask

  task automatic t_reset;
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 cfg_err", int'(cfg_err), 0);
    chk("R1 conv_clk_en", int'(conv_clk_en), 0);
    chk("R1 phases", int'({ph_wait, ph_sample, ph_convert}), 0);
  endtask

  task automatic t_mode_lock;
    int nb, nw, ns, nc, nd;
    wr_ctl(1'b0, 1'b0);
    trig_mode = 2'b00;
    wr_mode(3'd3, 2'b00);
    wr_ctl(1'b1, 1'b0);
    wr_mode(3'd0, 2'b01);
    chk("R7 err on locked mode write", int'(cfg_err), 1);
    wr_ctl(1'b1, 1'b1);
    wr_ctl(1'b1, 1'b0);
    measure(-1, nb, nw, ns, nc, nd);
    chk("R7 old divisor and variant kept", nb, 19 * 6);
  endtask

  task automatic t_start_no_en;
    int nb, nw, ns, nc, nd;
    int seen = 0;
    wr_ctl(1'b0, 1'b1);
    chk("R8 err on start without enable", int'(cfg_err), 1);
    repeat (10) begin
      @(negedge clk);
      if (busy) seen++;
    end
    chk("R8 no conversion begun", seen, 0);
    wr_ctl(1'b1, 1'b1);
    chk("R8 err cleared by good write", int'(cfg_err), 0);
    wr_ctl(1'b1, 1'b0);
    measure(-1, nb, nw, ns, nc, nd);
    chk("R8 enable kept across refused write", nb, 19 * 6);
  endtask

  task automatic t_illegal;
    int nb, nw, ns, nc, nd;
    wr_ctl(1'b0, 1'b0);
    trig_mode = 2'b00;
    wr_mode(3'd6, 2'b01);
    chk("R9 legal write no err", int'(cfg_err), 0);
    wr_mode(3'd3, 2'b10);
    chk("R9 err on variant 2", int'(cfg_err), 1);
    wr_mode(3'd7, 2'b00);
    chk("R9 err on divisor code 7", int'(cfg_err), 1);
    wr_ctl(1'b1, 1'b1);
    wr_ctl(1'b1, 1'b0);
    measure(-1, nb, nw, ns, nc, nd);
    chk("R9 settings unchanged", nb, 17 * 2);
    chk("R4 sample at /2", ns, 5 * 2);
  endtask

  task automatic t_repeat;
    int nb, nw, ns, nc, nd;
    wr_ctl(1'b0, 1'b0);
    trig_mode = 2'b00;
    wr_mode(3'd6, 2'b00);
    wr_ctl(1'b1, 1'b1);
    measure(-1, nb, nw, ns, nc, nd);
    chk("R11 first conversion", nb, 38);
    chk("R11 busy held at done", int'(busy), 1);
    @(negedge clk);
    measure(-1, nb, nw, ns, nc, nd);
    chk("R11 second conversion spacing", nb + 1, 38);
    chk("R11 second done", nd, 1);
    wr_ctl(1'b0, 1'b0);
  endtask

  task automatic t_retrig;
    int nb, nw, ns, nc, nd;
    wr_ctl(1'b0, 1'b0);
    trig_mode = 2'b01;
    wr_mode(3'd3, 2'b00);
    wr_ctl(1'b1, 1'b1);
    hw_trig = 1'b1;
    @(negedge clk);
    hw_trig = 1'b0;
    measure(30, nb, nw, ns, nc, nd);
    chk("R12 retrigger ignored", nb, 114);
    @(negedge clk);
    chk("R12 no restart after done", int'(busy), 0);
  endtask

  task automatic t_abort;
    int nbusy = 0;
    int ndone = 0;
    wr_ctl(1'b0, 1'b0);
    trig_mode = 2'b00;
    wr_mode(3'd0, 2'b00);
    wr_ctl(1'b1, 1'b1);
    repeat (50) @(negedge clk);
    chk("R13 running before abort", int'(busy), 1);
    wr_ctl(1'b0, 1'b0);
    @(negedge clk);
    repeat (40) begin
      if (busy) nbusy++;
      if (done) ndone++;
      @(negedge clk);
    end
    chk("R13 busy low after abort", nbusy, 0);
    chk("R13 no done after abort", ndone, 0);
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_sw(3'd0, 2'b00, 32, 19, 7, "R2 /32");
    run_sw(3'd3, 2'b00, 6, 19, 7, "R2 /6");
    run_sw(3'd4, 2'b00, 5, 19, 7, "R2 /5");
    run_sw(3'd6, 2'b00, 2, 19, 7, "R2 /2");
    run_sw(3'd3, 2'b01, 6, 17, 5, "R4 /6");
    run_sw(3'd0, 2'b01, 32, 17, 5, "R4 /32");
    run_hw(3'd0, 2'b10, 32, 21, 2, "R5 /32");
    run_hw(3'd3, 2'b11, 6, 21, 2, "R5 /6");
    run_hw(3'd4, 2'b01, 5, 19, 0, "R6 /5");
    t_mode_lock();
    t_start_no_en();
    t_illegal();
    t_repeat();
    t_retrig();
    t_abort();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule